// File: doc/BRIEF.md
# SD SPI Command/Response Engine

This block issues a single SD-mode command to a card attached over SPI and gathers the card's reply. A host hands over a 6-bit command index, a 32-bit argument, a 7-bit CRC and a response-type code in one valid/ready beat. The engine selects the card, waits a guard time, and serialises a six-byte command frame through a byte-wide SPI master port. It then keeps clocking idle filler bytes until the card answers, and collects the extra bytes that the selected response type carries. Finally it waits the guard time again, deselects the card and strobes the result back to the host.

The request port applies back-pressure simply: `req_ready` is high only while the engine is idle with the card deselected. A request is taken on a cycle where both `req_valid` and `req_ready` are high, and the command fields are latched at that point. Anything shown on `req_valid` while `req_ready` is low is ignored. Results are not back-pressured. `rsp_valid` pulses for one cycle, and `rsp_bytes`/`rsp_timeout` hold their values until the next request is accepted.

The SPI side is a request/acknowledge pair. The engine holds `spi_req` high with `spi_tx` stable until a cycle with `spi_ack` high. In that cycle one byte has been exchanged and `spi_rx` carries the received byte. `spi_req` may stay high across consecutive bytes.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first frame byte sent is the command index with bits 7:6 forced to 01 (index OR 0x40).
- R2: Frame bytes 2 to 5 carry the 32-bit argument, most significant byte first.
- R3: The sixth frame byte is the 7-bit CRC in bits 7:1 with bit 0 always 1.
- R4: `spi_cs_n` goes low at least GUARD_CYC cycles before the first `spi_req`. It stays low during every transfer, and it rises no earlier than GUARD_CYC cycles after the last acknowledge.
- R5: After the frame the engine sends 0xFF and takes the first received byte that is not 0xFF as response byte 0.
- R6: Polling stops after POLL_MAX (8) reads. If every polled byte was 0xFF, `rsp_timeout` is 1, response byte 0 is 0xFF, and no further transfers follow.
- R7: The type code selects how many bytes are collected: 0 = one byte, 1 = two bytes, 2 and 3 = five bytes, any other code = one byte. Bytes after the first are read back to back, whatever their value, with no polling.
- R8: `rsp_bytes` holds response byte 0 in bits 39:32 down to byte 4 in bits 7:0. Bytes that were not collected read 0xFF.
- R9: `req_ready` is high only when idle and deselected. A `req_valid` shown while `req_ready` is low starts nothing and does not change the command sent.
- R10: `rsp_valid` is a one-cycle pulse in the cycle `spi_cs_n` returns high. `rsp_bytes` and `rsp_timeout` stay stable afterwards until the next request is accepted.
- R11: While `spi_req` is high and no acknowledge has arrived, `spi_req` stays high and `spi_tx` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host command request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 7 | Command CRC (without end bit) |
| req_rtype | input | 3 | Response type code (0 one byte, 1 two bytes, 2/3 five bytes) |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_bytes | output | 40 | Collected response, byte 0 in the top byte |
| rsp_timeout | output | 1 | No response byte seen within the poll limit |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte transfer request to SPI master |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte received, valid with spi_ack |

## Verification
Commands are tried with card replies that start after several idle bytes, immediately, exactly on the last allowed poll, and never. These separate the poll bound and the timeout flag from the normal accept path. The one-, two- and five-byte types are given trailing bytes equal to 0xFF, which shows that trailing bytes are read without polling, and leaves later bytes uncollected, which shows the 0xFF fill. Frame contents are compared with several indices, arguments and CRCs so that byte order and the forced bits stand out. The guard timing and the ignored busy request are measured at the pins.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_LEN = 6;
  localparam int RSP_BYTES = 5;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SEND, ST_POLL, ST_COLLECT, ST_HOLD, ST_DONE
  } eng_state_t;

  // number of response bytes selected by the type code
  function automatic logic [2:0] rsp_len(input logic [2:0] code);
    case (code)
      3'd1:       rsp_len = 3'd2;
      3'd2, 3'd3: rsp_len = 3'd5;
      default:    rsp_len = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame
  import sd_cmd_pkg::*;
(
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [6:0]  cmd_crc,
  input  logic [2:0]  sel,
  output logic [7:0]  tx_byte
);
  logic [7:0] fb [FRAME_LEN];

  assign fb[0] = {2'b01, cmd_idx};
  for (genvar g = 1; g <= 4; g++) begin : g_arg
    assign fb[g] = cmd_arg[8*(4-g) +: 8];
  end
  assign fb[FRAME_LEN-1] = {cmd_crc, 1'b1};

  always_comb begin
    tx_byte = IDLE_BYTE;
    for (int i = 0; i < FRAME_LEN; i++)
      if (sel == i[2:0]) tx_byte = fb[i];
  end
endmodule

// File: rtl/sd_cmd_guard.sv
module sd_cmd_guard #(
  parameter int GUARD_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(GUARD_CYC - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sd_cmd_rspbuf.sv
module sd_cmd_rspbuf
  import sd_cmd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   we,
  input  logic [2:0]             widx,
  input  logic [7:0]             wdata,
  output logic [8*RSP_BYTES-1:0] flat
);
  logic [7:0] b [RSP_BYTES];

  for (genvar g = 0; g < RSP_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              b[g] <= IDLE_BYTE;
      else if (clear)                          b[g] <= IDLE_BYTE;
      else if (we && widx == 3'(g))            b[g] <= wdata;
    end
    assign flat[8*(RSP_BYTES-1-g) +: 8] = b[g];
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int GUARD_CYC = 1250,
  parameter int POLL_MAX  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [5:0]             req_index,
  input  logic [31:0]            req_arg,
  input  logic [6:0]             req_crc,
  input  logic [2:0]             req_rtype,
  output logic                   rsp_valid,
  output logic [8*RSP_BYTES-1:0] rsp_bytes,
  output logic                   rsp_timeout,
  output logic                   spi_cs_n,
  output logic                   spi_req,
  output logic [7:0]             spi_tx,
  input  logic                   spi_ack,
  input  logic [7:0]             spi_rx
);
  localparam int PW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX);

  eng_state_t    state;
  logic [5:0]    l_idx;
  logic [31:0]   l_arg;
  logic [6:0]    l_crc;
  logic [2:0]    need;
  logic [2:0]    sidx;
  logic [2:0]    cidx;
  logic [PW-1:0] pcnt;
  logic          tmo_q;

  logic accept, got_first, poll_last, go_hold, guard_start, guard_done;
  logic buf_we, buf_clear;
  logic [2:0] buf_widx;
  logic [7:0] frame_byte;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign got_first = (state == ST_POLL) && spi_ack && (spi_rx != IDLE_BYTE);
  assign poll_last = (pcnt == PW'(POLL_MAX - 1));
  always_comb begin
    go_hold = 1'b0;
    if (spi_ack) begin
      if (state == ST_POLL)
        go_hold = got_first ? (need == 3'd1) : poll_last;
      else if (state == ST_COLLECT)
        go_hold = (cidx == need - 3'd1);
    end
  end
  assign guard_start = accept || go_hold;
  assign buf_clear   = accept;
  assign buf_we      = spi_ack && ((state == ST_POLL) || (state == ST_COLLECT));
  assign buf_widx    = (state == ST_POLL) ? 3'd0 : cidx;

  sd_cmd_frame u_frame (
    .cmd_idx (l_idx),
    .cmd_arg (l_arg),
    .cmd_crc (l_crc),
    .sel     (sidx),
    .tx_byte (frame_byte)
  );

  sd_cmd_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (guard_start),
    .expired (guard_done)
  );

  sd_cmd_rspbuf u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (buf_clear),
    .we    (buf_we),
    .widx  (buf_widx),
    .wdata (spi_rx),
    .flat  (rsp_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      l_idx <= '0;
      l_arg <= '0;
      l_crc <= '0;
      need  <= 3'd1;
      sidx  <= '0;
      cidx  <= '0;
      pcnt  <= '0;
      tmo_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          l_idx <= req_index;
          l_arg <= req_arg;
          l_crc <= req_crc;
          need  <= rsp_len(req_rtype);
          tmo_q <= 1'b0;
          state <= ST_SETUP;
        end
        ST_SETUP: if (guard_done) begin
          sidx  <= '0;
          state <= ST_SEND;
        end
        ST_SEND: if (spi_ack) begin
          if (sidx == 3'(FRAME_LEN - 1)) begin
            pcnt  <= '0;
            state <= ST_POLL;
          end else begin
            sidx <= sidx + 3'd1;
          end
        end
        ST_POLL: if (spi_ack) begin
          if (got_first) begin
            cidx  <= 3'd1;
            state <= go_hold ? ST_HOLD : ST_COLLECT;
          end else if (poll_last) begin
            tmo_q <= 1'b1;
            state <= ST_HOLD;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_COLLECT: if (spi_ack) begin
          if (go_hold) state <= ST_HOLD;
          else         cidx  <= cidx + 3'd1;
        end
        ST_HOLD: if (guard_done) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_timeout = tmo_q;
  assign spi_cs_n    = (state == ST_IDLE) || (state == ST_DONE);
  assign spi_req     = (state == ST_SEND) || (state == ST_POLL) || (state == ST_COLLECT);
  assign spi_tx      = (state == ST_SEND) ? frame_byte : IDLE_BYTE;
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk
  import sd_cmd_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic [8*RSP_BYTES-1:0] rsp_bytes,
  input logic                   rsp_timeout,
  input logic                   spi_cs_n,
  input logic                   spi_req,
  input logic [7:0]             spi_tx,
  input logic                   spi_ack
);
  AST_REQ_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> !spi_cs_n); // R4
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !spi_req && !rsp_valid)); // R9
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_CS_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> rsp_valid); // R10
  AST_TIMEOUT_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (rsp_bytes[8*RSP_BYTES-1 -: 8] == IDLE_BYTE)); // R6
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (.*);

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
  localparam int G = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [5:0] req_index = 0;
  logic [31:0] req_arg = 0;
  logic [6:0] req_crc = 0;
  logic [2:0] req_rtype = 0;
  logic rsp_valid, rsp_timeout, spi_cs_n, spi_req;
  logic [39:0] rsp_bytes;
  logic [7:0] spi_tx;
  logic spi_ack = 0;
  logic [7:0] spi_rx = 8'hFF;

  sd_cmd_engine #(.GUARD_CYC(G), .POLL_MAX(8)) uut (.*);

  always #4 clk = ~clk;

  int total = 0, passed = 0, cyc = 0, done_flag = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // card model state
  logic [7:0] rq [16];
  int rn = 0, nxfer = 0, lat = 0, wcnt = 0, last_ack_cyc = 0;
  logic [7:0] txl [32];

  initial begin
    forever begin
      @(negedge clk);
      if (spi_ack) spi_ack = 0;
      else if (spi_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          if (nxfer < 32) txl[nxfer] = spi_tx;
          if (nxfer < 6) spi_rx = 8'hFF;
          else if (nxfer - 6 < rn) spi_rx = rq[nxfer-6];
          else spi_rx = 8'hFF;
          nxfer++;
          last_ack_cyc = cyc;
          spi_ack = 1;
        end
      end
    end
  end

  // pin monitor for chip-select timing
  int cs_lo_cyc = 0, first_req_cyc = 0, cs_hi_cyc = 0;
  logic prev_cs = 1, seen_req = 0;
  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin cs_lo_cyc = cyc; seen_req = 0; end
    if (!spi_cs_n && spi_req && !seen_req) begin first_req_cyc = cyc; seen_req = 1; end
    if (!prev_cs && spi_cs_n) cs_hi_cyc = cyc;
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
  endtask

  task automatic load_card(input logic [7:0] b [16], input int n, input int l);
    for (int i = 0; i < 16; i++) rq[i] = b[i];
    rn = n; lat = l; nxfer = 0;
  endtask

  task automatic start_cmd(input logic [5:0] ix, input logic [31:0] a, input logic [6:0] c, input logic [2:0] t);
    @(negedge clk);
    req_index = ix; req_arg = a; req_crc = c; req_rtype = t; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output logic [39:0] b, output logic to);
    while (!rsp_valid) @(negedge clk);
    b = rsp_bytes; to = rsp_timeout;
    @(negedge clk);
    chk(!rsp_valid && rsp_bytes == b, "R10 pulse/hold", {rsp_valid, rsp_bytes}, {1'b0, b});
  endtask

  task automatic check_frame(input logic [5:0] ix, input logic [31:0] a, input logic [6:0] c);
    chk(txl[0] == {2'b01, ix}, "R1 byte0", txl[0], {2'b01, ix});
    chk({txl[1], txl[2], txl[3], txl[4]} == a, "R2 argument", {txl[1], txl[2], txl[3], txl[4]}, a);
    chk(txl[5] == {c, 1'b1}, "R3 crc byte", txl[5], {c, 1'b1});
    chk(txl[6] == 8'hFF, "R5 filler", txl[6], 8'hFF);
  endtask

  task automatic check_guard();
    chk(first_req_cyc - cs_lo_cyc >= G, "R4 setup guard", first_req_cyc - cs_lo_cyc, G);
    chk(cs_hi_cyc - last_ack_cyc >= G, "R4 hold guard", cs_hi_cyc - last_ack_cyc, G);
  endtask

  task automatic t_reset();
    chk(spi_cs_n && req_ready && !spi_req && !rsp_valid, "R9 reset state",
        {spi_cs_n, req_ready, spi_req, rsp_valid}, 4'b1100);
    chk(rsp_bytes == 40'hFFFFFFFFFF, "R8 reset bytes", rsp_bytes, 40'hFFFFFFFFFF);
  endtask

  task automatic t_one_byte();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[3] = 8'h01;
    load_card(b, 4, 1);
    start_cmd(6'd0, 32'h0, 7'h4A, 3'd0);
    wait_done(r, to);
    check_frame(6'd0, 32'h0, 7'h4A);
    chk(r == 40'h01FFFFFFFF && !to, "R5 first non-idle byte", r, 40'h01FFFFFFFF);
    chk(nxfer == 10, "R7 one byte count", nxfer, 10);
    check_guard();
  endtask

  task automatic t_five_byte();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[1] = 8'h01; b[2] = 8'h00; b[3] = 8'h00; b[4] = 8'h01; b[5] = 8'hAA;
    load_card(b, 6, 0);
    start_cmd(6'd8, 32'h000001AA, 7'h43, 3'd3);
    wait_done(r, to);
    check_frame(6'd8, 32'h000001AA, 7'h43);
    chk(r == 40'h01000001AA, "R7 five bytes", r, 40'h01000001AA);
    chk(nxfer == 12, "R7 five byte count", nxfer, 12);
    check_guard();
  endtask

  task automatic t_two_byte_idle_second();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[0] = 8'h00; b[1] = 8'hFF; b[2] = 8'h55;
    load_card(b, 3, 2);
    start_cmd(6'd13, 32'hDEADBEEF, 7'h7F, 3'd1);
    wait_done(r, to);
    check_frame(6'd13, 32'hDEADBEEF, 7'h7F);
    chk(r == 40'h00FFFFFFFF, "R8 two bytes, rest idle", r, 40'h00FFFFFFFF);
    chk(nxfer == 8, "R7 no polling after first", nxfer, 8);
  endtask

  task automatic t_r3_mid_idle();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[0] = 8'h00; b[1] = 8'hC0; b[2] = 8'hFF; b[3] = 8'h80; b[4] = 8'h00;
    load_card(b, 5, 0);
    start_cmd(6'd58, 32'h12345678, 7'h00, 3'd2);
    wait_done(r, to);
    chk(r == 40'h00C0FF8000, "R7 trailing idle byte kept", r, 40'h00C0FF8000);
    chk(nxfer == 11, "R7 r3 count", nxfer, 11);
  endtask

  task automatic t_timeout();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    load_card(b, 0, 1);
    start_cmd(6'd17, 32'h00000200, 7'h11, 3'd0);
    wait_done(r, to);
    chk(to == 1'b1, "R6 timeout flag", to, 1);
    chk(r == 40'hFFFFFFFFFF, "R6 idle result", r, 40'hFFFFFFFFFF);
    chk(nxfer == 14, "R6 poll bound", nxfer, 14);
    check_guard();
  endtask

  task automatic t_last_poll();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[7] = 8'h04;
    load_card(b, 8, 0);
    start_cmd(6'd55, 32'h0, 7'h32, 3'd0);
    wait_done(r, to);
    chk(!to && r == 40'h04FFFFFFFF, "R6 answer on last poll", {to, r}, {1'b0, 40'h04FFFFFFFF});
    chk(nxfer == 14, "R6 last poll count", nxfer, 14);
  endtask

  task automatic t_unknown_type();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to;
    b[0] = 8'h00; b[1] = 8'h12; b[2] = 8'h34;
    load_card(b, 3, 0);
    start_cmd(6'd41, 32'h40000000, 7'h05, 3'd5);
    wait_done(r, to);
    chk(r == 40'h00FFFFFFFF && nxfer == 7, "R7 other code as one byte", r, 40'h00FFFFFFFF);
  endtask

  task automatic t_busy_ignored();
    logic [7:0] b [16] = '{default: 8'hFF};
    logic [39:0] r; logic to; int n0; int bad = 0;
    b[0] = 8'h00;
    load_card(b, 1, 0);
    start_cmd(6'd9, 32'hA5A5A5A5, 7'h2C, 3'd0);
    @(negedge clk);
    req_index = 6'd24; req_arg = 32'h11111111; req_crc = 7'h01; req_valid = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (req_ready) bad++;
    end
    req_valid = 0;
    chk(bad == 0, "R9 not ready while busy", bad, 0);
    wait_done(r, to);
    check_frame(6'd9, 32'hA5A5A5A5, 7'h2C);
    n0 = nxfer;
    repeat (20) @(negedge clk);
    chk(spi_cs_n && nxfer == n0 && rsp_bytes == 40'h00FFFFFFFF, "R9 busy request ignored",
        nxfer, n0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_one_byte();
    t_five_byte();
    t_two_byte_idle_second();
    t_r3_mid_idle();
    t_timeout();
    t_last_poll();
    t_unknown_type();
    t_busy_ignored();
    done_flag = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end
endmodule